// File: doc/BRIEF.md
# Majority-Vote Bit Accumulator

This block forms one dimension of a binary class hypervector during single-pass training. For every feature of every training sample of one class, the encoder presents the level-hypervector bit for this dimension. The block counts the bits that are logic-1 and reports whether that count has reached half the feature count. That majority point is the sign used when the accumulated class vector is binarized. A full class hypervector is built by placing one instance per dimension, from about a thousand up to ten thousand of them, side by side. All instances share the clear, valid and end-marker strobes.

No magnitude comparator is used. The threshold `FEATURES/2` is fixed at elaboration, so only the counter bits at positions where the threshold has a 1 are gathered into a single AND gate. Because the count rises by one at a time, that gate first fires at exactly the threshold. The AND can fall again once the count moves past the threshold, so the decision is captured in a sticky flag. A synchronous clear starts a new class accumulation. An end marker raises a done flag that holds until the next clear.

Top module: `maj_bit_binarizer`

## Requirements
- R1: After reset, `class_bit_o` and `done_o` are 0.
- R2: The count advances only on a cycle with `valid_i`=1 and `bit_i`=1. Cycles with `valid_i`=0, whatever `bit_i` holds, and valid cycles with `bit_i`=0 do not move `class_bit_o` toward 1.
- R3: With threshold T = floor(FEATURES/2), `class_bit_o` is 0 after T-1 counted ones. It reads 1 after the clock edge that registers the T-th counted one.
- R4: Once `class_bit_o` is 1, it stays 1 while further ones are counted, including counts where the masked threshold bits no longer all read 1 (for FEATURES=784, a count of 400). It falls only at a clear.
- R5: After a clock edge with `clear_i`=1, both outputs read 0 (given T of at least 2). A valid one presented in the clear cycle is counted as the first one of the new accumulation.
- R6: `done_o` reads 1 after the edge that samples `last_i`=1, whether or not `valid_i` is set. It holds 1 until the edge that samples `clear_i`=1.
- R7: For an odd FEATURES the threshold is floor(FEATURES/2). For FEATURES=7, three counted ones set `class_bit_o` and two do not.
- R8: When `last_i` arrives together with the counted one that reaches T, `class_bit_o` and `done_o` both change to 1 after the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Start a new class accumulation (synchronous) |
| valid_i | input | 1 | `bit_i` carries a level-hypervector bit this cycle |
| bit_i | input | 1 | Level-hypervector bit for this dimension |
| last_i | input | 1 | End marker of the accumulation |
| class_bit_o | output | 1 | Binarized class-hypervector bit |
| done_o | output | 1 | Accumulation finished |

## Verification
Two events can coincide in one cycle. The first is the end marker arriving together with the counted one that reaches the threshold. The second is a clear arriving together with a valid one, which must then become the first one of the new class rather than being dropped. Both cases are provoked on purpose. The first is judged by requiring `done_o` and `class_bit_o` to rise after the same edge. The second is judged by requiring the bit to rise after exactly T-1 further ones. A behavioural model using plain integers is compared on every clock, against a default instance and against an odd-sized instance with FEATURES=7.

// File: rtl/majbin_pkg.sv
package majbin_pkg;

    typedef struct packed {
        logic hit;
        logic done;
    } dec_state_t;

endpackage

// File: rtl/sat_popcounter.sv
module sat_popcounter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_next_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] base;

    always_comb begin
        base  = clear_i ? '0 : cnt_q;
        cnt_d = base;
        if (inc_i && (base != CNT_MAX)) begin
            cnt_d = base + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_next_o = cnt_d;
endmodule

// File: rtl/thresh_mask_and.sv
module thresh_mask_and #(
    parameter int CNT_W  = 10,
    parameter int THRESH = 392
) (
    input  logic [CNT_W-1:0] cnt_i,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] MASK = CNT_W'(THRESH);

    logic [CNT_W-1:0] gated;

    for (genvar i = 0; i < CNT_W; i++) begin : g_tap
        if (MASK[i]) begin : g_wire
            assign gated[i] = cnt_i[i];
        end else begin : g_tie
            assign gated[i] = 1'b1;
        end
    end

    assign hit_o = &gated;
endmodule

// File: rtl/maj_bit_binarizer.sv
module maj_bit_binarizer
    import majbin_pkg::*;
#(
    parameter int FEATURES = 784
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic valid_i,
    input  logic bit_i,
    input  logic last_i,
    output logic class_bit_o,
    output logic done_o
);
    localparam int CNT_W = $clog2(FEATURES);
    localparam int TOB   = FEATURES / 2;

    logic [CNT_W-1:0] cnt_next;
    logic             hit_now;
    dec_state_t       st_d, st_q;

    sat_popcounter #(.CNT_W(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear_i),
        .inc_i      (valid_i & bit_i),
        .cnt_next_o (cnt_next)
    );

    thresh_mask_and #(.CNT_W(CNT_W), .THRESH(TOB)) u_mask (
        .cnt_i (cnt_next),
        .hit_o (hit_now)
    );

    always_comb begin
        st_d = clear_i ? '0 : st_q;
        st_d.hit  = st_d.hit | hit_now;
        st_d.done = st_d.done | last_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign class_bit_o = st_q.hit;
    assign done_o      = st_q.done;
endmodule

// File: rtl/maj_bit_binarizer_chk.sv
module maj_bit_binarizer_chk #(
    parameter int FEATURES = 784
) (
    input logic clk,
    input logic rst_n,
    input logic clear_i,
    input logic valid_i,
    input logic bit_i,
    input logic last_i,
    input logic class_bit_o,
    input logic done_o
);
    localparam int TOB = FEATURES / 2;

    int unsigned ones_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q <= 0;
        end else if (clear_i) begin
            ones_q <= 32'(valid_i & bit_i);
        end else if (valid_i && bit_i && ones_q < 32'hFFFF_0000) begin
            ones_q <= ones_q + 1;
        end
    end

    AST_BIT_MATCHES_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        class_bit_o == (ones_q >= TOB)); // R3
    AST_BIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        class_bit_o && !clear_i |=> class_bit_o); // R4
    AST_RISE_NEEDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(class_bit_o) |-> $past(valid_i && bit_i)); // R2
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i && !last_i |=> !class_bit_o && !done_o); // R5
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_i |=> done_o); // R6
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !clear_i |=> done_o); // R6
endmodule

bind maj_bit_binarizer maj_bit_binarizer_chk #(.FEATURES(FEATURES)) u_chk (.*);

// File: tb/test_maj_bit_binarizer.sv
module test_maj_bit_binarizer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear_i = 1'b0, valid_i = 1'b0, bit_i = 1'b0, last_i = 1'b0;
    logic bit_a, done_a, bit_b, done_b;
    int checks = 0, fails = 0;
    string cur_req = "R1";
    bit finished = 1'b0;

    always #4 clk = ~clk;

    maj_bit_binarizer #(.FEATURES(784)) i_maj_bit_binarizer (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .valid_i(valid_i),
        .bit_i(bit_i), .last_i(last_i), .class_bit_o(bit_a), .done_o(done_a));

    maj_bit_binarizer #(.FEATURES(7)) i_maj_bit_binarizer_odd (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .valid_i(valid_i),
        .bit_i(bit_i), .last_i(last_i), .class_bit_o(bit_b), .done_o(done_b));

    // behavioural reference: counts, sticky flags
    int  cnt_a = 0, cnt_b = 0;
    bit  hit_a = 0, hit_b = 0, dn_a = 0, dn_b = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt_a = 0; cnt_b = 0; hit_a = 0; hit_b = 0; dn_a = 0; dn_b = 0;
        end else begin
            if (clear_i) begin
                cnt_a = 0; cnt_b = 0; hit_a = 0; hit_b = 0; dn_a = 0; dn_b = 0;
            end
            if (valid_i && bit_i) begin
                cnt_a++; cnt_b++;
            end
            if (cnt_a >= 392) hit_a = 1;
            if (cnt_b >= 3)   hit_b = 1;
            if (last_i) begin dn_a = 1; dn_b = 1; end
        end
    end

    task automatic expect_bit(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            expect_bit(cur_req, "model bit_a",  bit_a,  hit_a);
            expect_bit(cur_req, "model done_a", done_a, dn_a);
            expect_bit(cur_req, "model bit_b",  bit_b,  hit_b);
            expect_bit(cur_req, "model done_b", done_b, dn_b);
        end
    end

    task automatic step(logic c, logic v, logic b, logic l);
        @(posedge clk); #2;
        clear_i = c; valid_i = v; bit_i = b; last_i = l;
    endtask

    task automatic settle();
        step(0, 0, 0, 0);
        #3;
    endtask

    task automatic ones(int n);
        for (int i = 0; i < n; i++) step(0, 1, 1, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #3;
        expect_bit("R1", "reset bit_a", bit_a, 1'b0);
        expect_bit("R1", "reset done_a", done_a, 1'b0);
        expect_bit("R1", "reset bit_b", bit_b, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        cur_req = "R2";
        step(1, 0, 0, 0);
        ones(2);
        for (int i = 0; i < 10; i++) step(0, 0, 1, 0);
        for (int i = 0; i < 10; i++) step(0, 1, 0, 0);
        settle();
        expect_bit("R2", "ignored bits odd", bit_b, 1'b0);
        expect_bit("R7", "two ones odd", bit_b, 1'b0);
        cur_req = "R7";
        ones(1); settle();
        expect_bit("R7", "three ones odd", bit_b, 1'b1);

        cur_req = "R3";
        ones(388); settle();
        expect_bit("R3", "T-1 ones", bit_a, 1'b0);
        ones(1); settle();
        expect_bit("R3", "T ones", bit_a, 1'b1);

        cur_req = "R4";
        ones(10); settle();
        expect_bit("R4", "count 402", bit_a, 1'b1);

        cur_req = "R6";
        step(0, 0, 0, 1); settle();
        expect_bit("R6", "done after last", done_a, 1'b1);
        repeat (5) step(0, 0, 0, 0);
        settle();
        expect_bit("R6", "done holds", done_a, 1'b1);

        cur_req = "R5";
        step(1, 1, 1, 0); settle();
        expect_bit("R5", "clear bit", bit_a, 1'b0);
        expect_bit("R5", "clear done", done_a, 1'b0);
        ones(390); settle();
        expect_bit("R5", "T-1 incl clear one", bit_a, 1'b0);
        ones(1); settle();
        expect_bit("R5", "clear-cycle one counted", bit_a, 1'b1);

        cur_req = "R8";
        step(1, 0, 0, 0);
        ones(391); settle();
        expect_bit("R8", "before joint edge bit", bit_a, 1'b0);
        expect_bit("R8", "before joint edge done", done_a, 1'b0);
        step(0, 1, 1, 1); settle();
        expect_bit("R8", "joint bit", bit_a, 1'b1);
        expect_bit("R8", "joint done", done_a, 1'b1);

        cur_req = "R4";
        ones(1100); settle();
        expect_bit("R4", "long run odd", bit_b, 1'b1);
        expect_bit("R4", "long run", bit_a, 1'b1);

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++; fails++;
            $display("FAIL %s watchdog: actual hung expected finish", cur_req);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule